// File: doc/BRIEF.md
# Quadrature Phasor Estimator

This block estimates the amplitude, RMS value and phase angle of a nominally 50 Hz sinusoid from four ADC readings taken a quarter period apart. Once `enable` is high, an internal interval timer issues a one-cycle sample request every programmed number of clock cycles. The returned reading is accepted through a valid/ready handshake on the sample port. After the fourth accepted reading, the block forms an in-phase and quadrature pair with the DC offset removed. An iterative 16-step vectoring CORDIC then turns that pair into a magnitude and an angle. The magnitude is corrected for CORDIC gain and scaled to RMS. All three results are published together with a one-cycle done strobe.

The offset is removed pairwise. Readings half a cycle apart carry the same offset and opposite signal, so half their difference is the offset-free component. This gives A = (s0 − s2)/2 and B = (s1 − s3)/2, where s0..s3 are the readings in acceptance order. The sample port follows these rules. `smp_ready` rises the cycle after a request and stays high until the first cycle in which `smp_valid` is also high. A reading is consumed only in that cycle. `smp_valid` is ignored while `smp_ready` is low, so the ADC side may hold or withdraw data freely without losing or duplicating a reading.

Top module: `phasor_quad_est`

## Requirements
- R1: While `enable` is high, `smp_req` pulses for one cycle once every interval cycles. The interval is `cfg_interval`, or the parameter `DEF_IVL` when `cfg_interval` is 0. The first pulse comes on the cycle after `enable` is first seen high.
- R2: While `enable` is low, `smp_req` and `smp_ready` stay low. Dropping `enable` discards a partly collected set, and the next set starts again at s0.
- R3: `smp_ready` goes high the cycle after `smp_req` and holds until a cycle with `smp_valid` high, which is the only kind of cycle that consumes a reading. `smp_valid` asserted while `smp_ready` is low has no effect on the results.
- R4: Readings are unsigned DATA_W-bit codes, numbered s0..s3 in acceptance order. A = (s0 − s2)/2 and B = (s1 − s3)/2, so any common DC level cancels.
- R5: `res_peak` equals sqrt(A² + B²) within ±2 LSB.
- R6: `res_rms` equals sqrt(A² + B²)/√2 within ±2 LSB, and never exceeds `res_peak`.
- R7: `res_phase` is atan2(B, A) as a signed binary angle where 2^15 means 180 degrees, in the range [−180°, 180°), within ±24 LSB. All four quadrants are covered, including A < 0.
- R8: `res_done` pulses for one cycle no more than 24 cycles after the fourth reading is accepted. The result outputs change only in that cycle and hold otherwise.
- R9: After reset, `smp_req`, `smp_ready`, `res_done`, `res_peak`, `res_rms` and `res_phase` are all 0.
- R10: When A = B = 0 (all four readings equal), `res_peak`, `res_rms` and `res_phase` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Starts the sampling schedule; low clears it |
| cfg_interval | input | IVL_W | Clock cycles between requests; 0 selects DEF_IVL |
| smp_req | output | 1 | One-cycle request to start an ADC conversion |
| smp_valid | input | 1 | A reading is present on smp_data |
| smp_ready | output | 1 | The block will consume a reading this cycle if valid |
| smp_data | input | DATA_W | Unsigned ADC reading |
| res_done | output | 1 | One-cycle strobe: new results on the outputs |
| res_peak | output | DATA_W+1 | Peak magnitude |
| res_rms | output | DATA_W+1 | RMS value |
| res_phase | output | 16 | Signed phase angle, 2^15 = 180 degrees |

## Verification
On every cycle, the assertions check four things:
- The request spacing against the programmed or default interval.
- The silence of the request and ready pins while the block is disabled.
- That ready holds until a handshake.
- That the done strobe lasts one cycle, the results stay stable outside it, and RMS stays at or below peak.

Only the bench's scenarios can show several other behaviours:
- The numeric accuracy of peak, RMS and phase in every quadrant, including the ±180° wrap and a tiny-amplitude case.
- That the constant-input case gives zeros.
- That a partial set is discarded when enable drops.
- That data offered while ready is low leaves the results untouched.

// File: rtl/phq_pkg.sv
package phq_pkg;

  localparam int ANG_W  = 16;
  localparam int ITERS  = 16;
  localparam int ITER_W = $clog2(ITERS);

  // 1/K for a 16-step vectoring CORDIC and 1/sqrt(2), both in Q0.16
  localparam int GAIN_INV_Q16 = 39797;
  localparam int RMS_Q16      = 46341;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ITER,
    ST_GAIN,
    ST_OUT
  } cordic_st_t;

  // atan(2^-i) as a binary angle, 2^15 = 180 degrees
  function automatic logic [ANG_W-1:0] atan_step(input logic [ITER_W-1:0] i);
    case (i)
      4'd0:    return 16'd8192;
      4'd1:    return 16'd4836;
      4'd2:    return 16'd2555;
      4'd3:    return 16'd1297;
      4'd4:    return 16'd651;
      4'd5:    return 16'd326;
      4'd6:    return 16'd163;
      4'd7:    return 16'd81;
      4'd8:    return 16'd41;
      4'd9:    return 16'd20;
      4'd10:   return 16'd10;
      4'd11:   return 16'd5;
      4'd12:   return 16'd3;
      4'd13:   return 16'd1;
      4'd14:   return 16'd1;
      default: return 16'd0;
    endcase
  endfunction

endpackage

// File: rtl/phq_timer.sv
module phq_timer #(
  parameter int IVL_W   = 20,
  parameter int DEF_IVL = 625000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [IVL_W-1:0] cfg_interval,
  output logic             req_o
);

  localparam logic [IVL_W-1:0] DEF_V = IVL_W'(DEF_IVL);

  logic [IVL_W-1:0] cnt;
  logic [IVL_W-1:0] period;
  logic             fire;

  assign period = (cfg_interval == '0) ? DEF_V : cfg_interval;
  assign fire   = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      req_o <= 1'b0;
    end else if (!enable) begin
      cnt   <= '0;
      req_o <= 1'b0;
    end else begin
      req_o <= fire;
      cnt   <= fire ? (period - 1'b1) : (cnt - 1'b1);
    end
  end

endmodule

// File: rtl/phq_capture.sv
module phq_capture #(
  parameter int DATA_W = 12,
  localparam int IN_W  = DATA_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   req_i,
  input  logic                   valid_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic                   ready_o,
  output logic                   start_o,
  output logic signed [IN_W-1:0] a2_o,
  output logic signed [IN_W-1:0] b2_o
);

  logic [DATA_W-1:0] samp [4];
  logic [1:0]        idx;
  logic              waiting;
  logic              take;

  assign take    = valid_i && waiting;
  assign ready_o = waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      waiting <= 1'b0;
      start_o <= 1'b0;
      for (int k = 0; k < 4; k++) samp[k] <= '0;
    end else if (!enable) begin
      idx     <= '0;
      waiting <= 1'b0;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (take) begin
        samp[idx] <= data_i;
        idx       <= idx + 1'b1;
        waiting   <= 1'b0;
        start_o   <= (idx == 2'd3);
      end
      if (req_i) waiting <= 1'b1;
    end
  end

  // twice the offset-free components: half-cycle pairs cancel the DC level
  assign a2_o = $signed({1'b0, samp[0]}) - $signed({1'b0, samp[2]});
  assign b2_o = $signed({1'b0, samp[1]}) - $signed({1'b0, samp[3]});

endmodule

// File: rtl/phq_cordic.sv
module phq_cordic
  import phq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FRAC   = 6,
  localparam int IN_W  = DATA_W + 1,
  localparam int PW    = DATA_W + 1,
  localparam int XW    = IN_W + FRAC + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [IN_W-1:0]  a2_i,
  input  logic signed [IN_W-1:0]  b2_i,
  output logic                    done_o,
  output logic [PW-1:0]           peak_o,
  output logic [PW-1:0]           rms_o,
  output logic signed [ANG_W-1:0] phase_o
);

  cordic_st_t              st;
  logic [ITER_W-1:0]       iter;
  logic signed [XW-1:0]    x, y;
  logic signed [ANG_W-1:0] z;
  logic                    zero_q;
  logic [PW-1:0]           pk_q;

  logic signed [XW-1:0]    xa, yb, xs, ys;
  logic [XW+15:0]          prod_g;
  logic [PW+15:0]          prod_r;
  logic signed [ANG_W-1:0] dz;

  always_comb begin
    xa     = XW'(a2_i) <<< FRAC;
    yb     = XW'(b2_i) <<< FRAC;
    xs     = x >>> iter;
    ys     = y >>> iter;
    dz     = $signed(atan_step(iter));
    prod_g = (XW+16)'($unsigned(x)) * (XW+16)'(GAIN_INV_Q16);
    prod_r = (PW+16)'(pk_q) * (PW+16)'(RMS_Q16);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      iter    <= '0;
      x       <= '0;
      y       <= '0;
      z       <= '0;
      zero_q  <= 1'b0;
      pk_q    <= '0;
      done_o  <= 1'b0;
      peak_o  <= '0;
      rms_o   <= '0;
      phase_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        // left half-plane: rotate by 180 degrees first, angle wraps modulo 2^16
        if (a2_i < 0) begin
          x <= -xa;
          y <= -yb;
          z <= $signed(16'h8000);
        end else begin
          x <= xa;
          y <= yb;
          z <= '0;
        end
        zero_q <= (a2_i == '0) && (b2_i == '0);
        iter   <= '0;
        st     <= ST_ITER;
      end else begin
        case (st)
          ST_ITER: begin
            if (!y[XW-1]) begin
              x <= x + ys;
              y <= y - xs;
              z <= z + dz;
            end else begin
              x <= x - ys;
              y <= y + xs;
              z <= z - dz;
            end
            iter <= iter + 1'b1;
            if (iter == ITER_W'(ITERS - 1)) st <= ST_GAIN;
          end
          ST_GAIN: begin
            // inputs were doubled, hence one extra bit of shift
            pk_q <= PW'(prod_g >> (16 + FRAC + 1));
            st   <= ST_OUT;
          end
          ST_OUT: begin
            peak_o  <= pk_q;
            rms_o   <= PW'(prod_r >> 16);
            phase_o <= zero_q ? '0 : z;
            done_o  <= 1'b1;
            st      <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/phasor_quad_est.sv
module phasor_quad_est
  import phq_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int IVL_W   = 20,
  parameter int DEF_IVL = 625000,
  parameter int FRAC    = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [IVL_W-1:0]        cfg_interval,
  output logic                    smp_req,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic [DATA_W-1:0]       smp_data,
  output logic                    res_done,
  output logic [DATA_W:0]         res_peak,
  output logic [DATA_W:0]         res_rms,
  output logic signed [ANG_W-1:0] res_phase
);

  localparam int IN_W = DATA_W + 1;

  logic                   start;
  logic signed [IN_W-1:0] a2, b2;

  phq_timer #(.IVL_W(IVL_W), .DEF_IVL(DEF_IVL)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .cfg_interval (cfg_interval),
    .req_o        (smp_req)
  );

  phq_capture #(.DATA_W(DATA_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .req_i   (smp_req),
    .valid_i (smp_valid),
    .data_i  (smp_data),
    .ready_o (smp_ready),
    .start_o (start),
    .a2_o    (a2),
    .b2_o    (b2)
  );

  phq_cordic #(.DATA_W(DATA_W), .FRAC(FRAC)) u_cordic (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .a2_i    (a2),
    .b2_i    (b2),
    .done_o  (res_done),
    .peak_o  (res_peak),
    .rms_o   (res_rms),
    .phase_o (res_phase)
  );

endmodule

// File: rtl/phq_checker.sv
module phq_checker #(
  parameter int DATA_W  = 12,
  parameter int IVL_W   = 20,
  parameter int DEF_IVL = 625000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [IVL_W-1:0]  cfg_interval,
  input logic              smp_req,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              res_done,
  input logic [DATA_W:0]   res_peak,
  input logic [DATA_W:0]   res_rms,
  input logic [15:0]       res_phase
);

  logic [IVL_W:0] gap;
  logic           seen;
  logic [IVL_W:0] want;

  assign want = (cfg_interval == '0) ? (IVL_W+1)'(DEF_IVL) : {1'b0, cfg_interval};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (!enable) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (smp_req) begin
      gap  <= (IVL_W+1)'(1);
      seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  assert_req_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && smp_req && seen) |-> (gap == want));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!smp_req && !smp_ready));

  assert_ready_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req && enable) |=> smp_ready);

  assert_ready_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && !smp_valid && enable) |=> smp_ready);

  assert_rms_le_peak_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_rms <= res_peak);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> ($stable(res_peak) && $stable(res_rms) && $stable(res_phase)));

endmodule

bind phasor_quad_est phq_checker #(
  .DATA_W (DATA_W),
  .IVL_W  (IVL_W),
  .DEF_IVL(DEF_IVL)
) u_phq_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .cfg_interval (cfg_interval),
  .smp_req      (smp_req),
  .smp_valid    (smp_valid),
  .smp_ready    (smp_ready),
  .res_done     (res_done),
  .res_peak     (res_peak),
  .res_rms      (res_rms),
  .res_phase    (res_phase)
);

// File: tb/phasor_quad_est_bench.sv
module phasor_quad_est_bench;

  localparam int DATA_W  = 12;
  localparam int IVL_W   = 20;
  localparam int DEF_IVL = 40;
  localparam int NVEC    = 7;
  localparam real PI     = 3.14159265358979;

  // stimulus: s0..s3 per set; expected results computed from R4..R7, R10
  localparam logic [11:0] VEC [NVEC][4] = '{
    '{12'd3048, 12'd2548, 12'd1048, 12'd1548},
    '{12'd1048, 12'd2948, 12'd3048, 12'd1148},
    '{12'd1500, 12'd1000, 12'd2596, 12'd3096},
    '{12'd4000, 12'd100,  12'd96,   12'd3996},
    '{12'd1000, 12'd2048, 12'd3000, 12'd2048},
    '{12'd2060, 12'd2055, 12'd2036, 12'd2041},
    '{12'd1234, 12'd1234, 12'd1234, 12'd1234}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enable = 1'b0;
  logic [IVL_W-1:0]  cfg_interval = '0;
  logic              smp_req;
  logic              smp_valid = 1'b0;
  logic              smp_ready;
  logic [DATA_W-1:0] smp_data = '0;
  logic              res_done;
  logic [DATA_W:0]   res_peak;
  logic [DATA_W:0]   res_rms;
  logic signed [15:0] res_phase;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  phasor_quad_est #(.DATA_W(DATA_W), .IVL_W(IVL_W), .DEF_IVL(DEF_IVL), .FRAC(6)) u_phasor_quad_est (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_interval(cfg_interval),
    .smp_req(smp_req), .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .res_done(res_done), .res_peak(res_peak), .res_rms(res_rms), .res_phase(res_phase)
  );

  task automatic check_near(input string req, input int act, input int exp, input int tol);
    n_tests++;
    if (act - exp > tol || exp - act > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  task automatic check_phase(input string req, input int act, input int exp);
    int d;
    d = act - exp;
    while (d >= 32768) d -= 65536;
    while (d < -32768) d += 65536;
    n_tests++;
    if (d > 24 || d < -24) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_one(input logic [11:0] d);
    int guard = 0;
    while (!smp_ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    smp_valid = 1'b1;
    smp_data  = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!res_done && lat < 500) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic measure_gap(output int g);
    int guard = 0;
    while (!smp_req && guard < 2000) begin @(negedge clk); guard++; end
    g = 0;
    do begin @(negedge clk); g++; end while (!smp_req && g < 2000);
  endtask

  task automatic check_set(input int k, input string tag);
    real ea, eb, pk;
    int  eph;
    ea  = (real'(int'(VEC[k][0])) - real'(int'(VEC[k][2]))) / 2.0;
    eb  = (real'(int'(VEC[k][1])) - real'(int'(VEC[k][3]))) / 2.0;
    pk  = $sqrt(ea * ea + eb * eb);
    eph = (ea == 0.0 && eb == 0.0) ? 0 : int'($atan2(eb, ea) * 32768.0 / PI);
    check_near({"R5 peak ", tag}, int'(res_peak), int'(pk), 2);
    check_near({"R6 rms ", tag},  int'(res_rms),  int'(pk / $sqrt(2.0)), 2);
    check_phase({"R7 phase ", tag}, int'(res_phase), eph);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int g, lat;
    string tag;

    // R9: reset state
    repeat (3) @(negedge clk);
    check_near("R9 req",   int'(smp_req),   0, 0);
    check_near("R9 ready", int'(smp_ready), 0, 0);
    check_near("R9 done",  int'(res_done),  0, 0);
    check_near("R9 peak",  int'(res_peak),  0, 0);
    check_near("R9 rms",   int'(res_rms),   0, 0);
    check_near("R9 phase", int'(res_phase), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: default interval and first request timing
    enable = 1'b1;
    @(negedge clk);
    check_near("R1 first request", int'(smp_req), 1, 0);
    measure_gap(g);
    check_near("R1 default spacing", g, DEF_IVL, 0);

    // table walk: R4..R7, R10 and R8 latency
    for (int k = 0; k < NVEC; k++) begin
      for (int j = 0; j < 4; j++) send_one(VEC[k][j]);
      wait_done(lat);
      $sformat(tag, "vec%0d", k);
      check_near({"R8 latency ", tag}, (lat >= 1 && lat <= 24) ? 1 : 0, 1, 0);
      check_set(k, tag);
      if (k == NVEC - 1) begin
        check_near("R10 zero peak",  int'(res_peak),  0, 0);
        check_near("R10 zero phase", int'(res_phase), 0, 0);
      end
    end

    // R8: results hold without a new set
    enable = 1'b0;
    g = int'(res_peak);
    repeat (30) @(negedge clk);
    check_near("R8 hold peak", int'(res_peak), g, 0);

    // R2: quiet while disabled
    lat = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (smp_req || smp_ready) lat++;
    end
    check_near("R2 quiet when disabled", lat, 0, 0);

    // R1: programmed interval
    cfg_interval = 25;
    enable = 1'b1;
    measure_gap(g);
    check_near("R1 programmed spacing", g, 25, 0);

    // R2: partial set dropped on disable
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    send_one(12'd4095);
    send_one(12'd0);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    for (int j = 0; j < 4; j++) send_one(VEC[0][j]);
    wait_done(lat);
    check_set(0, "R2 after partial");

    // R3: valid while ready is low is ignored
    send_one(VEC[3][0]);
    lat = 0;
    smp_valid = 1'b1;
    smp_data  = 12'd4095;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (smp_ready) lat++;
    end
    smp_valid = 1'b0;
    check_near("R3 ready low during junk", lat, 0, 0);
    for (int j = 1; j < 4; j++) send_one(VEC[3][j]);
    wait_done(lat);
    check_set(3, "R3 junk ignored");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule